// File: doc/BRIEF.md
# Packet Buffer Host Access Window

This block gives a host a single 16-bit data window into an on-chip packet buffer and a handful of small configuration targets. A select code routes the window to local packet memory, to one of several station-address slots, to a read-only identification value, or to the transmit-end register. For packet memory, the host loads a byte address and a direction. It then streams words through the window, and every access moves the buffer address on by two bytes.

An 8-word FIFO sits between the window and the memory. The memory accepts or supplies one FIFO word per memory slot, where a slot comes every DRAIN_GAP+1 cycles. In write mode, host words queue in the FIFO and drain to memory in the background. In read mode, the FIFO prefetches ahead of the host. The host watches the direction, empty and full flags, and it is held off through a ready signal when the FIFO cannot serve it. A new address or direction that arrives while write data is still queued is held back until the queue has drained. A request that arrives in read mode takes effect at once and discards the prefetched words.

Top module: `pktbuf_window`

## Requirements
- R1: After reset the FIFO is in write mode (fifo_dir_o=0), empty, not full, and addr_err_o=0. The select code is local memory, the transmit-end value is 0x00, all station slots are zero, and win_ready_o is 1.
- R2: With select code 6 (local memory) in write mode, each accepted window write queues one word. Queued words are stored at consecutive word addresses, starting at the loaded byte address, 2 bytes per access. While 8 words are queued, fifo_full_o is 1 and win_ready_o is 0. fifo_empty_o returns to 1 only after every queued word has been stored.
- R3: An address load or direction change requested while write-mode words remain queued takes effect only once the FIFO is empty. Until then, fifo_dir_o keeps its old value. In read mode, such a request takes effect on the next cycle and discards the prefetched words.
- R4: In read mode, the FIFO prefetches consecutive words starting at the loaded byte address. fifo_full_o rises when 8 words are held, and each window read returns the next word in order.
- R5: In read mode, fifo_full_o is also 1 when the prefetch has reached the end of memory and at least one word is held.
- R6: In read mode with local memory selected and the FIFO empty, win_ready_o is 0 and no data is consumed.
- R7: Select code 4 reads a fixed identification word. With ENHANCED=1 it is 0x00A1, whose bits [7:4] are 0xA. With ENHANCED=0 it is 0x0005.
- R8: A window write with select code 5 stores bits [7:0] as the transmit-end value (for example, 0x3F for a 16 KB transmit area). Reading the window under code 5 returns that value zero-extended.
- R9: Select codes 0 to NSLOT-1 address station slots. After the select code is written, the first six window writes load bytes 0 to 5 from bits [7:0]. Byte 0 goes to slot bits [47:40] and byte 5 to bits [7:0]. Further writes are ignored, and writing the select code again restarts at byte 0.
- R10: An address load at or beyond 2*MEM_WORDS bytes is ignored, and addr_err_o is 1 for the one cycle that follows it.
- R11: fifo_empty_o and fifo_full_o are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_we_i | input | 1 | Load the window select code |
| sel_i | input | 3 | Select code: 0..3 station slots, 4 ident, 5 transmit end, 6 local memory, 7 none |
| addr_we_i | input | 1 | Load the buffer byte address |
| addr_i | input | 16 | Buffer byte address |
| dir_we_i | input | 1 | Load the FIFO direction |
| dir_rd_i | input | 1 | Requested direction, 1 = read |
| win_wr_i | input | 1 | Window write request |
| win_wdata_i | input | 16 | Window write data |
| win_rd_i | input | 1 | Window read request |
| win_rdata_o | output | 16 | Window read data, valid with win_ready_o |
| win_ready_o | output | 1 | Window access completes at this clock edge |
| fifo_dir_o | output | 1 | Active FIFO direction, 1 = read |
| fifo_empty_o | output | 1 | FIFO holds no words |
| fifo_full_o | output | 1 | FIFO full, or read prefetch at end of memory |
| addr_err_o | output | 1 | Previous address load was out of range |
| tx_end_o | output | 8 | Transmit-end value |
| stn_addr_o | output | NSLOT*48 | Station slots, slot s at bits [s*48 +: 48] |

## Verification
The hardest situation to reach is an address or direction change that arrives while write data is still queued. When host writes and memory drains run at the same rate, the queue never grows deep enough to expose a deferral. The stimulus therefore relies on the memory slot arriving only every fourth cycle. The host writes back to back so that several words pile up, then loads a new address and selects read mode at once. The bench checks that the direction flag has not yet changed, and that the readback shows every queued word landed at its original address.

// File: rtl/bw_pkg.sv
package bw_pkg;
  localparam logic [2:0] SEL_PID   = 3'd4;
  localparam logic [2:0] SEL_TXEND = 3'd5;
  localparam logic [2:0] SEL_MEM   = 3'd6;
  localparam logic [2:0] SEL_NONE  = 3'd7;
  localparam int unsigned STN_BYTES = 6;
endpackage

// File: rtl/bw_fifo.sv
module bw_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         flush_i,
  input  logic                         push_i,
  input  logic                         pop_i,
  input  logic [W-1:0]                 din_i,
  output logic [W-1:0]                 dout_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o
);
  localparam int unsigned IW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic [W-1:0]  store_q [DEPTH];
  logic [IW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= wr_q + 1'b1;
      if (pop_i)  rd_q <= rd_q + 1'b1;
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) store_q[wr_q] <= din_i;
  end

  assign dout_o  = store_q[rd_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/bw_mem.sv
module bw_mem #(
  parameter int unsigned WORDS = 1024,
  parameter int unsigned W     = 16
) (
  input  logic                     clk_i,
  input  logic                     we_i,
  input  logic [$clog2(WORDS)-1:0] waddr_i,
  input  logic [W-1:0]             wdata_i,
  input  logic [$clog2(WORDS)-1:0] raddr_i,
  output logic [W-1:0]             rdata_o
);
  logic [W-1:0] arr_q [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) arr_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = arr_q[raddr_i];
endmodule

// File: rtl/bw_regs.sv
module bw_regs #(
  parameter int unsigned NSLOT = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sel_we_i,
  input  logic [2:0]         sel_q_i,
  input  logic               wr_i,
  input  logic [7:0]         wbyte_i,
  output logic [7:0]         tx_end_o,
  output logic [NSLOT*48-1:0] stn_o
);
  import bw_pkg::*;

  logic [2:0]  idx_q;
  logic [7:0]  tx_end_q;
  logic [47:0] slot_q [NSLOT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q    <= '0;
      tx_end_q <= '0;
    end else if (sel_we_i) begin
      idx_q <= '0;
    end else if (wr_i) begin
      if (int'(sel_q_i) < int'(NSLOT) && int'(idx_q) < int'(STN_BYTES)) idx_q <= idx_q + 1'b1;
      if (sel_q_i == SEL_TXEND) tx_end_q <= wbyte_i;
    end
  end

  for (genvar s = 0; s < int'(NSLOT); s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_q[s] <= '0;
      end else if (!sel_we_i && wr_i && int'(sel_q_i) == s && int'(idx_q) < int'(STN_BYTES)) begin
        slot_q[s][8*(5-int'(idx_q)) +: 8] <= wbyte_i;
      end
    end
    assign stn_o[s*48 +: 48] = slot_q[s];
  end

  assign tx_end_o = tx_end_q;
endmodule

// File: rtl/pktbuf_window.sv
module pktbuf_window #(
  parameter int unsigned MEM_WORDS  = 1024,
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned NSLOT      = 4,
  parameter int unsigned DRAIN_GAP  = 3,
  parameter bit          ENHANCED   = 1'b1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sel_we_i,
  input  logic [2:0]            sel_i,
  input  logic                  addr_we_i,
  input  logic [15:0]           addr_i,
  input  logic                  dir_we_i,
  input  logic                  dir_rd_i,
  input  logic                  win_wr_i,
  input  logic [15:0]           win_wdata_i,
  input  logic                  win_rd_i,
  output logic [15:0]           win_rdata_o,
  output logic                  win_ready_o,
  output logic                  fifo_dir_o,
  output logic                  fifo_empty_o,
  output logic                  fifo_full_o,
  output logic                  addr_err_o,
  output logic [7:0]            tx_end_o,
  output logic [NSLOT*48-1:0]   stn_addr_o
);
  import bw_pkg::*;

  localparam int unsigned MEM_BYTES = 2 * MEM_WORDS;
  localparam int unsigned IW        = $clog2(MEM_WORDS);
  localparam int unsigned AW        = IW + 1;
  localparam int unsigned CW        = $clog2(FIFO_DEPTH + 1);
  localparam int unsigned GW        = $clog2(DRAIN_GAP + 2);
  localparam logic [15:0] PID       = ENHANCED ? 16'h00A1 : 16'h0005;

  logic [2:0]    sel_q;
  logic          req_rd_q, req_pend_q, act_rd_q, addr_err_q;
  logic [AW-1:0] req_ptr_q, ptr_q;
  logic [GW-1:0] gap_q;
  logic [CW-1:0] count;
  logic [15:0]   fifo_dout, mem_rdata, fifo_din;
  logic          addr_bad, addr_ok, slot, is_mem, empty, cnt_full, at_end, apply;
  logic          host_push, host_pop, drain, fetch;

  assign addr_bad = addr_we_i && (32'(addr_i) >= MEM_BYTES);
  assign addr_ok  = addr_we_i && !addr_bad;
  assign slot     = (gap_q == '0);
  assign is_mem   = (sel_q == SEL_MEM);
  assign empty    = (count == '0);
  assign cnt_full = (count == CW'(FIFO_DEPTH));
  assign at_end   = (ptr_q == AW'(MEM_WORDS));
  // requests wait for the write queue to drain; read mode switches at once
  assign apply    = req_pend_q && (act_rd_q || empty);

  assign host_push = is_mem && !act_rd_q && !req_pend_q && win_wr_i && !cnt_full;
  assign host_pop  = is_mem &&  act_rd_q && !req_pend_q && win_rd_i && !empty;
  assign drain     = !act_rd_q && !empty && slot;
  assign fetch     =  act_rd_q && !req_pend_q && !at_end && !cnt_full && slot;
  assign fifo_din  = act_rd_q ? mem_rdata : win_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q      <= SEL_MEM;
      req_rd_q   <= 1'b0;
      req_pend_q <= 1'b0;
      req_ptr_q  <= '0;
      act_rd_q   <= 1'b0;
      ptr_q      <= '0;
      addr_err_q <= 1'b0;
      gap_q      <= '0;
    end else begin
      if (sel_we_i) sel_q <= sel_i;
      addr_err_q <= addr_bad;
      gap_q      <= slot ? GW'(DRAIN_GAP) : gap_q - 1'b1;
      if (apply) req_pend_q <= 1'b0;
      if (dir_we_i) req_rd_q <= dir_rd_i;
      if (addr_ok) req_ptr_q <= AW'(addr_i >> 1);
      if (dir_we_i || addr_ok) req_pend_q <= 1'b1;
      if (apply) begin
        act_rd_q <= req_rd_q;
        ptr_q    <= req_ptr_q;
      end else if ((drain || fetch) && !at_end) begin
        ptr_q <= ptr_q + 1'b1;
      end
    end
  end

  bw_fifo #(.DEPTH(FIFO_DEPTH), .W(16)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (apply),
    .push_i  (host_push || fetch),
    .pop_i   (drain || host_pop),
    .din_i   (fifo_din),
    .dout_o  (fifo_dout),
    .count_o (count)
  );

  bw_mem #(.WORDS(MEM_WORDS), .W(16)) u_mem (
    .clk_i   (clk_i),
    .we_i    (drain && !at_end),
    .waddr_i (ptr_q[IW-1:0]),
    .wdata_i (fifo_dout),
    .raddr_i (ptr_q[IW-1:0]),
    .rdata_o (mem_rdata)
  );

  bw_regs #(.NSLOT(NSLOT)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_we_i (sel_we_i),
    .sel_q_i  (sel_q),
    .wr_i     (win_wr_i && !is_mem),
    .wbyte_i  (win_wdata_i[7:0]),
    .tx_end_o (tx_end_o),
    .stn_o    (stn_addr_o)
  );

  always_comb begin
    case (sel_q)
      SEL_MEM:   win_rdata_o = fifo_dout;
      SEL_PID:   win_rdata_o = PID;
      SEL_TXEND: win_rdata_o = {8'h00, tx_end_o};
      default:   win_rdata_o = 16'h0000;
    endcase
  end

  assign win_ready_o  = is_mem ? (!req_pend_q && (act_rd_q ? !empty : !cnt_full)) : 1'b1;
  assign fifo_dir_o   = act_rd_q;
  assign fifo_empty_o = empty;
  assign fifo_full_o  = cnt_full || (act_rd_q && at_end && !empty);
  assign addr_err_o   = addr_err_q;
endmodule

// File: rtl/pktbuf_window_chk.sv
module pktbuf_window_chk #(
  parameter int unsigned MEM_BYTES = 2048
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [2:0]  sel_q,
  input logic        fifo_dir_o,
  input logic        fifo_empty_o,
  input logic        fifo_full_o,
  input logic        win_ready_o,
  input logic        win_wr_i,
  input logic [7:0]  wbyte,
  input logic        addr_we_i,
  input logic [15:0] addr_i,
  input logic        addr_err_o,
  input logic [7:0]  tx_end_o
);
  import bw_pkg::*;

  AST_NOT_EMPTY_AND_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fifo_empty_o && fifo_full_o)); // R11

  AST_WR_FULL_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q == SEL_MEM && !fifo_dir_o && fifo_full_o) |-> !win_ready_o); // R2

  AST_DIR_SWITCH_DRAINED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(fifo_dir_o) |-> ($past(fifo_dir_o) || $past(fifo_empty_o))); // R3

  AST_RD_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q == SEL_MEM && fifo_dir_o && fifo_empty_o) |-> !win_ready_o); // R6

  AST_TXEND_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q == SEL_TXEND && win_wr_i) |=> (tx_end_o == $past(wbyte))); // R8

  AST_BAD_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_we_i && 32'(addr_i) >= MEM_BYTES) |=> addr_err_o); // R10
endmodule

bind pktbuf_window pktbuf_window_chk #(.MEM_BYTES(MEM_BYTES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sel_q        (sel_q),
  .fifo_dir_o   (fifo_dir_o),
  .fifo_empty_o (fifo_empty_o),
  .fifo_full_o  (fifo_full_o),
  .win_ready_o  (win_ready_o),
  .win_wr_i     (win_wr_i),
  .wbyte        (win_wdata_i[7:0]),
  .addr_we_i    (addr_we_i),
  .addr_i       (addr_i),
  .addr_err_o   (addr_err_o),
  .tx_end_o     (tx_end_o)
);

// File: tb/pktbuf_window_tb_top.sv
module pktbuf_window_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 1024;
  localparam int MEM_BYTES  = 2 * MEM_WORDS;
  localparam int NSLOT      = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_we = 0, addr_we = 0, dir_we = 0, dir_rd = 0, win_wr = 0, win_rd = 0;
  logic [2:0]  sel = 0;
  logic [15:0] addr = 0, wdata = 0;
  logic [15:0] rdata;
  logic ready, fdir, fempty, ffull, aerr;
  logic [7:0] tx_end;
  logic [NSLOT*48-1:0] stn;

  int n_tests = 0, n_fail = 0;
  bit saw_full = 0, both_seen = 0;
  logic [15:0] model [MEM_WORDS];
  logic [15:0] exp_q[$], got_q[$];
  string tag_q[$];
  event rd_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  pktbuf_window dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .sel_we_i(sel_we), .sel_i(sel),
    .addr_we_i(addr_we), .addr_i(addr),
    .dir_we_i(dir_we), .dir_rd_i(dir_rd),
    .win_wr_i(win_wr), .win_wdata_i(wdata), .win_rd_i(win_rd),
    .win_rdata_o(rdata), .win_ready_o(ready),
    .fifo_dir_o(fdir), .fifo_empty_o(fempty), .fifo_full_o(ffull),
    .addr_err_o(aerr), .tx_end_o(tx_end), .stn_addr_o(stn)
  );

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  // scoreboard monitor
  always @(rd_ev) begin
    while (got_q.size() > 0) begin
      logic [15:0] g;
      string t;
      g = got_q.pop_front();
      t = tag_q.pop_front();
      if (exp_q.size() == 0) chk({t, " (no expected word)"}, g, 64'hDEAD);
      else chk(t, g, exp_q.pop_front());
    end
  end

  task automatic set_sel(logic [2:0] c);
    sel_we = 1; sel = c; tick(); sel_we = 0;
  endtask
  task automatic load_addr(logic [15:0] a);
    addr_we = 1; addr = a; tick(); addr_we = 0;
  endtask
  task automatic set_dir(logic r);
    dir_we = 1; dir_rd = r; tick(); dir_we = 0;
  endtask

  task automatic win_write(logic [15:0] d);
    bit ok = 0;
    win_wr = 1; wdata = d;
    for (int i = 0; i < 400; i++) begin
      #1;
      if (ready) begin ok = 1; break; end
      if (ffull) saw_full = 1;
      tick();
    end
    tick();
    win_wr = 0;
    if (!ok) chk("R2 write accepted", 0, 1);
  endtask

  task automatic win_read(string t);
    bit ok = 0;
    logic [15:0] g = 0;
    win_rd = 1;
    for (int i = 0; i < 400; i++) begin
      #1;
      if (ready) begin ok = 1; g = rdata; break; end
      tick();
    end
    tick();
    win_rd = 0;
    if (!ok) chk({t, " read accepted"}, 0, 1);
    else begin got_q.push_back(g); tag_q.push_back(t); -> rd_ev; #1; end
  endtask

  task automatic expect_seq(int byte_a, int n);
    for (int k = 0; k < n; k++) exp_q.push_back(model[(byte_a >> 1) + k]);
  endtask

  task automatic mem_write_seq(int byte_a, int n, logic [15:0] seed);
    set_sel(3'd6); set_dir(0); load_addr(16'(byte_a));
    for (int k = 0; k < n; k++) begin
      logic [15:0] d;
      d = seed + 16'(k) * 16'h0101;
      model[(byte_a >> 1) + k] = d;
      win_write(d);
    end
  endtask

  task automatic wait_flag(bit want_full, int lim, output bit hit);
    hit = 0;
    for (int i = 0; i < lim; i++) begin
      if (fempty && ffull) both_seen = 1;
      if (want_full ? ffull : fempty) begin hit = 1; break; end
      tick();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    bit hit;
    for (int i = 0; i < MEM_WORDS; i++) model[i] = 16'h0;
    tick(); tick();
    rst_n = 1;
    tick();
    // R1 reset state
    chk("R1 dir", fdir, 0);
    chk("R1 empty", fempty, 1);
    chk("R1 full", ffull, 0);
    chk("R1 addr_err", aerr, 0);
    chk("R1 tx_end", tx_end, 0);
    chk("R1 stn", stn, 0);
    chk("R1 ready", ready, 1);

    // R2 background drain with write-mode full
    mem_write_seq(16'h0100, 12, 16'h1000);
    chk("R2 full seen during burst", saw_full, 1);
    chk("R2 not empty right after burst", fempty, 0);
    wait_flag(0, 200, hit);
    chk("R2 empty after drain", hit, 1);

    // R3 deferred address/direction while write queue pending
    mem_write_seq(16'h0200, 6, 16'h2000);
    load_addr(16'h0200);
    set_dir(1);
    chk("R3 dir held while draining", fdir, 0);
    chk("R3 queue still pending", fempty, 0);
    expect_seq(16'h0200, 6);
    for (int k = 0; k < 6; k++) win_read("R3 data at old address");

    // R4 prefetch to full, consecutive words
    load_addr(16'h0100);
    wait_flag(1, 200, hit);
    chk("R4 full after prefetch", hit, 1);
    chk("R4 not empty when full", fempty, 0);
    expect_seq(16'h0100, 8);
    for (int k = 0; k < 8; k++) win_read("R4 sequential word");

    // R10 out-of-range address ignored
    load_addr(16'(MEM_BYTES));
    chk("R10 addr_err pulse", aerr, 1);
    tick();
    chk("R10 addr_err clears", aerr, 0);
    expect_seq(16'h0100 + 16, 4);
    for (int k = 0; k < 4; k++) win_read("R10 read continues");

    // R5 full at end of memory, R6 stall when empty
    mem_write_seq(MEM_BYTES - 4, 2, 16'h3A00);
    load_addr(16'(MEM_BYTES - 4));
    set_dir(1);
    wait_flag(1, 200, hit);
    chk("R5 full at end of memory", hit, 1);
    expect_seq(MEM_BYTES - 4, 2);
    for (int k = 0; k < 2; k++) win_read("R5 last words");
    win_rd = 1;
    for (int i = 0; i < 4; i++) begin
      #1;
      chk("R6 ready low when empty", ready, 0);
      chk("R6 empty", fempty, 1);
      chk("R11 empty not full", ffull, 0);
      tick();
    end
    win_rd = 0;

    // R7 identification
    set_sel(3'd4);
    exp_q.push_back(16'h00A1);
    win_read("R7 ident");

    // R8 transmit end
    set_sel(3'd5);
    win_write(16'h123F);
    chk("R8 tx_end stored", tx_end, 8'h3F);
    exp_q.push_back(16'h003F);
    win_read("R8 tx_end readback");

    // R9 station slot
    set_sel(3'd1);
    for (int k = 0; k < 7; k++) win_write(16'hAB00 | 16'((k + 1) * 8'h11));
    chk("R9 slot1 six bytes, seventh ignored", stn[48 +: 48], 48'h112233445566);
    chk("R9 slot0 untouched", stn[0 +: 48], 48'h0);
    set_sel(3'd1);
    win_write(16'h00AA);
    win_write(16'h00BB);
    chk("R9 restart at byte 0", stn[48 +: 48], 48'hAABB33445566);

    chk("R11 never empty and full", both_seen, 0);
    tick();
    chk("scoreboard drained", exp_q.size(), 0);
    finish_up();
  end
endmodule